// File: doc/BRIEF.md
# Register Window Overflow Detector

This block decides whether a register reference made by a windowed function would overwrite a caller's frame that is still live in the register file. It holds no register contents. It sees the current window base, a live-frame bit vector with one bit per four-register window position, the number of four-register groups the instruction needs, the program counter and two status bits: overflow-enable and exception-mode. On a strobe it looks ahead of the base for the nearest live frame. If that frame falls inside the groups the instruction needs, the block raises a trap. It then reports the rotation, the spill size class, the base to save and the updated status and exception PC.

The spill size class is chosen from how far apart the next live frames lie beyond the one that was found. Frames close together need a small spill and sparse frames need a large one. The surrounding core uses these outputs to vector to the right spill handler and to rotate its window. All index arithmetic on the live-frame vector wraps modulo the number of window positions.

Top module: `wov_unit`

## Requirements
- R1: After reset every output is zero: trapPulse, spillClass, rotateBy, savedBase, newBase, excModeOut and exceptPc.
- R2: A trap is possible only when ovfEnable is 1 and excModeIn is 0. A strobe under any other combination gives trapPulse 0, spillClass 0, rotateBy 0, newBase equal to baseIn and excModeOut equal to excModeIn, and leaves savedBase and exceptPc unchanged.
- R3: For k = 1 up to needGroups, the block tests liveMask at position (baseIn + k) mod NUM_POS, and the first set bit fixes n = k. If no bit is set in that range there is no trap. needGroups = 0 never traps.
- R4: On a trap, rotateBy = n and newBase = (baseIn + n) mod NUM_POS.
- R5: On a trap, savedBase takes the pre-rotation baseIn and excModeOut is 1.
- R6: On a trap, exceptPc takes pcIn. On every other strobe it keeps its previous value.
- R7: With m = (baseIn + n) mod NUM_POS, spillClass is 2'b01 (four registers) if the liveMask bit at (m+1) mod NUM_POS is set. Otherwise it is 2'b10 (eight registers) if the bit at (m+2) mod NUM_POS is set. Otherwise it is 2'b11 (twelve registers). 2'b00 means no trap.
- R8: Outputs update only at a clock edge where checkStb is 1 and are valid right after that edge. trapPulse is high for one cycle per trapping strobe. In a cycle without a strobe, trapPulse is 0 and all other outputs hold.
- R9: The look-ahead and the class positions wrap past the last window position back to position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| checkStb | input | 1 | Evaluate the current inputs this cycle |
| baseIn | input | BASE_W | Current window base |
| liveMask | input | NUM_POS | Live-frame bit per window position |
| needGroups | input | 2 | Four-register groups referenced (0 to 3) |
| pcIn | input | PC_W | PC of the referencing instruction |
| ovfEnable | input | 1 | Window overflow checking enabled |
| excModeIn | input | 1 | Exception mode currently set |
| trapPulse | output | 1 | One-cycle overflow trap request |
| spillClass | output | 2 | 01/10/11 = 4/8/12-register spill, 00 = none |
| rotateBy | output | 2 | Forward window rotation n |
| savedBase | output | BASE_W | Old window base to keep in status |
| newBase | output | BASE_W | Window base after the check |
| excModeOut | output | 1 | Updated exception-mode bit |
| exceptPc | output | PC_W | First-level exception PC |

## Verification
The bench sweeps every base with every group count against random live-frame patterns. This catches a scan that runs one position too far, starts at the base itself, or fails to wrap; each of those shows up as a wrong rotation or a spurious trap near position NUM_POS-1. Directed wrap cases place the class-deciding bits past position 0. A design that indexes without the modulo would report class 12 where 4 or 8 is due. Gating cases with either status bit in its blocking state catch a design that still traps. They also catch one that corrupts the saved base or exception PC on a strobe that did not trap.

// File: rtl/wov_pkg.sv
package wov_pkg;
  // Spill size classes as seen on spillClass
  typedef enum logic [1:0] {
    SPILL_NONE = 2'b00,
    SPILL_4    = 2'b01,
    SPILL_8    = 2'b10,
    SPILL_12   = 2'b11
  } spillClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // a check is evaluated this cycle
    logic takeTrap;  // the evaluated check raises a trap
  } wovCtl_t;
endpackage

// File: rtl/wov_ctrl.sv
module wov_ctrl (
  input  logic            clk,
  input  logic            rstN,
  input  logic            checkStb,
  input  logic            ovfEnable,
  input  logic            excModeIn,
  input  logic            scanHit,
  output wov_pkg::wovCtl_t ctl,
  output logic            trapPulse
);
  logic armed;

  // Checking applies only with overflow enabled and outside exception mode
  assign armed        = ovfEnable & ~excModeIn;
  assign ctl.capture  = checkStb;
  assign ctl.takeTrap = checkStb & armed & scanHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapPulse <= 1'b0;
    else       trapPulse <= ctl.takeTrap;
  end

  // R2: a blocked status never yields a trap
  a_r2_gated_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && (!ovfEnable || excModeIn)) |=> !trapPulse);

  // R8: no strobe, no trap
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> !trapPulse);
endmodule

// File: rtl/wov_datapath.sv
module wov_datapath #(
  parameter int NUM_POS = 16,
  parameter int PC_W    = 32,
  localparam int BASE_W = $clog2(NUM_POS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  wov_pkg::wovCtl_t    ctl,
  input  logic [BASE_W-1:0]   baseIn,
  input  logic [NUM_POS-1:0]  liveMask,
  input  logic [1:0]          needGroups,
  input  logic [PC_W-1:0]     pcIn,
  input  logic                excModeIn,
  output logic                scanHit,
  output logic [1:0]          spillClass,
  output logic [1:0]          rotateBy,
  output logic [BASE_W-1:0]   savedBase,
  output logic [BASE_W-1:0]   newBase,
  output logic                excModeOut,
  output logic [PC_W-1:0]     exceptPc
);
  import wov_pkg::*;

  localparam int LOOK = 5;  // up to 3 scan positions plus 2 class positions

  // Live bits at wrapped positions base+1 .. base+5
  logic [LOOK:1] ahead;
  for (genvar j = 1; j <= LOOK; j++) begin : g_ahead
    logic [BASE_W-1:0] pos;
    assign pos      = baseIn + BASE_W'(j);
    assign ahead[j] = liveMask[pos];
  end

  logic [1:0]  hitN;
  logic [2:0]  idxA, idxB;
  spillClass_e cls;

  // Nearest live frame within the referenced groups
  always_comb begin
    scanHit = 1'b0;
    hitN    = 2'd0;
    for (int k = 1; k <= 3; k++) begin
      if (!scanHit && (2'(k) <= needGroups) && ahead[k]) begin
        scanHit = 1'b1;
        hitN    = 2'(k);
      end
    end
  end

  // Class from the spacing of the next live frames past the hit
  always_comb begin
    idxA = 3'(hitN) + 3'd1;
    idxB = 3'(hitN) + 3'd2;
    if (ahead[idxA])      cls = SPILL_4;
    else if (ahead[idxB]) cls = SPILL_8;
    else                  cls = SPILL_12;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spillClass <= '0;
      rotateBy   <= '0;
      savedBase  <= '0;
      newBase    <= '0;
      excModeOut <= 1'b0;
      exceptPc   <= '0;
    end else if (ctl.capture) begin
      if (ctl.takeTrap) begin
        spillClass <= cls;
        rotateBy   <= hitN;
        newBase    <= baseIn + BASE_W'(hitN);
        savedBase  <= baseIn;
        excModeOut <= 1'b1;
        exceptPc   <= pcIn;
      end else begin
        spillClass <= SPILL_NONE;
        rotateBy   <= 2'd0;
        newBase    <= baseIn;
        excModeOut <= excModeIn;
      end
    end
  end

  // R5/R6: status fields only move on a trap
  a_r6_pc_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.takeTrap |=> ($stable(exceptPc) && $stable(savedBase)));

  // R4: the new base sits rotateBy ahead of the saved base after a trap
  a_r4_rotate: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeTrap |=> (newBase == savedBase + BASE_W'(rotateBy)));

  // R3: the rotation never exceeds the referenced group count
  a_r3_within_w: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeTrap |=> (rotateBy != 2'd0 && rotateBy <= $past(needGroups)));
endmodule

// File: rtl/wov_unit.sv
module wov_unit #(
  parameter int NUM_POS = 16,
  parameter int PC_W    = 32,
  localparam int BASE_W = $clog2(NUM_POS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               checkStb,
  input  logic [BASE_W-1:0]  baseIn,
  input  logic [NUM_POS-1:0] liveMask,
  input  logic [1:0]         needGroups,
  input  logic [PC_W-1:0]    pcIn,
  input  logic               ovfEnable,
  input  logic               excModeIn,
  output logic               trapPulse,
  output logic [1:0]         spillClass,
  output logic [1:0]         rotateBy,
  output logic [BASE_W-1:0]  savedBase,
  output logic [BASE_W-1:0]  newBase,
  output logic               excModeOut,
  output logic [PC_W-1:0]    exceptPc
);
  wov_pkg::wovCtl_t ctl;
  logic scanHit;

  wov_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .checkStb(checkStb), .ovfEnable(ovfEnable),
    .excModeIn(excModeIn), .scanHit(scanHit), .ctl(ctl), .trapPulse(trapPulse)
  );

  wov_datapath #(.NUM_POS(NUM_POS), .PC_W(PC_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseIn(baseIn), .liveMask(liveMask),
    .needGroups(needGroups), .pcIn(pcIn), .excModeIn(excModeIn),
    .scanHit(scanHit), .spillClass(spillClass), .rotateBy(rotateBy),
    .savedBase(savedBase), .newBase(newBase), .excModeOut(excModeOut),
    .exceptPc(exceptPc)
  );

  // R5/R7: a trap always sets exception mode and names a spill class
  a_r5_trap_fields: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> (excModeOut && spillClass != 2'b00));

  // R3: zero groups referenced never traps
  a_r3_w_zero: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && needGroups == 2'd0) |=> !trapPulse);

  // R8: outputs hold without a strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> ($stable(newBase) && $stable(spillClass) && $stable(excModeOut)));
endmodule

// File: tb/test_wov_unit.sv
module test_wov_unit;
  localparam int N  = 16;
  localparam int BW = 4;
  localparam int PW = 32;

  logic clk = 1'b0, rstN = 1'b0, checkStb = 1'b0;
  logic [BW-1:0] baseIn = '0;
  logic [N-1:0]  liveMask = '0;
  logic [1:0]    needGroups = '0;
  logic [PW-1:0] pcIn = '0;
  logic ovfEnable = 1'b0, excModeIn = 1'b0;
  logic trapPulse, excModeOut;
  logic [1:0] spillClass, rotateBy;
  logic [BW-1:0] savedBase, newBase;
  logic [PW-1:0] exceptPc;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [BW-1:0] modelSaved = '0;
  logic [PW-1:0] modelPc = '0;

  always #2 clk = ~clk;  // 250 MHz

  wov_unit #(.NUM_POS(N), .PC_W(PW)) i_wov_unit (
    .clk(clk), .rstN(rstN), .checkStb(checkStb), .baseIn(baseIn),
    .liveMask(liveMask), .needGroups(needGroups), .pcIn(pcIn),
    .ovfEnable(ovfEnable), .excModeIn(excModeIn), .trapPulse(trapPulse),
    .spillClass(spillClass), .rotateBy(rotateBy), .savedBase(savedBase),
    .newBase(newBase), .excModeOut(excModeOut), .exceptPc(exceptPc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Apply one strobe, then compare every output against the model
  task automatic strobe(logic [BW-1:0] b, logic [N-1:0] mask, logic [1:0] w,
                        logic [PW-1:0] pc, logic en, logic ex, string req);
    int n, m, cls;
    bit trap;
    @(negedge clk);
    baseIn = b; liveMask = mask; needGroups = w; pcIn = pc;
    ovfEnable = en; excModeIn = ex; checkStb = 1'b1;
    @(negedge clk);
    checkStb = 1'b0;
    trap = 0; n = 0; cls = 0;
    if (en && !ex) begin
      for (int k = 1; k <= int'(w); k++)
        if (!trap && mask[(int'(b) + k) % N]) begin trap = 1; n = k; end
    end
    if (trap) begin
      m = (int'(b) + n) % N;
      if (mask[(m + 1) % N])      cls = 1;
      else if (mask[(m + 2) % N]) cls = 2;
      else                        cls = 3;
      modelSaved = b;
      modelPc = pc;
    end
    chk(req, "trapPulse", 32'(trapPulse), 32'(trap));
    chk(req, "rotateBy R4", 32'(rotateBy), 32'(n));
    chk(req, "newBase R4", 32'(newBase), 32'((int'(b) + n) % N));
    chk(req, "spillClass R7", 32'(spillClass), 32'(cls));
    chk(req, "excModeOut R5", 32'(excModeOut), trap ? 32'd1 : 32'(ex));
    chk(req, "savedBase R5", 32'(savedBase), 32'(modelSaved));
    chk(req, "exceptPc R6", exceptPc, modelPc);
  endtask

  task automatic test_reset();
    chk("R1", "trapPulse", 32'(trapPulse), 0);
    chk("R1", "spillClass", 32'(spillClass), 0);
    chk("R1", "rotateBy", 32'(rotateBy), 0);
    chk("R1", "savedBase", 32'(savedBase), 0);
    chk("R1", "newBase", 32'(newBase), 0);
    chk("R1", "excModeOut", 32'(excModeOut), 0);
    chk("R1", "exceptPc", exceptPc, 0);
  endtask

  task automatic test_gating();
    strobe(4'd3, 16'h0010, 2'd1, 32'h1000, 1'b1, 1'b0, "R3");   // traps
    strobe(4'd3, 16'h0010, 2'd1, 32'h2000, 1'b0, 1'b0, "R2");   // disabled
    strobe(4'd3, 16'h0010, 2'd1, 32'h3000, 1'b1, 1'b1, "R2");   // in exception
    strobe(4'd3, 16'h0010, 2'd1, 32'h4000, 1'b0, 1'b1, "R2");
  endtask

  task automatic test_w_zero();
    strobe(4'd5, 16'hFFFF, 2'd0, 32'h5000, 1'b1, 1'b0, "R3");
    strobe(4'd5, 16'h0100, 2'd2, 32'h5004, 1'b1, 1'b0, "R3");   // bit at +3 outside w=2
  endtask

  task automatic test_wrap();
    // base 15, hit at position 0 (n=1), class bit at position 1
    strobe(4'd15, 16'h0003, 2'd1, 32'h6000, 1'b1, 1'b0, "R9");
    // base 14, hit at 1 (n=3), bit at 3 -> class 8
    strobe(4'd14, 16'h0008 | 16'h0002, 2'd3, 32'h6004, 1'b1, 1'b0, "R9");
    // only the hit bit set -> class 12
    strobe(4'd13, 16'h8000, 2'd2, 32'h6008, 1'b1, 1'b0, "R7");
    // nearest frame wins over a later one
    strobe(4'd0, 16'h000C, 2'd3, 32'h600C, 1'b1, 1'b0, "R3");
  endtask

  task automatic test_hold();
    strobe(4'd7, 16'h0100, 2'd1, 32'h7000, 1'b1, 1'b0, "R8");
    @(negedge clk);
    chk("R8", "trapPulse one cycle", 32'(trapPulse), 0);
    chk("R8", "newBase held", 32'(newBase), 32'd8);
    chk("R8", "exceptPc held", exceptPc, 32'h7000);
    chk("R8", "spillClass held", 32'(spillClass), 32'd3);
  endtask

  task automatic test_sweep();
    for (int b = 0; b < N; b++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 4; p++)
          strobe(BW'(b), N'($urandom), 2'(w), $urandom, 1'b1, 1'b0, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_gating();
    test_w_zero();
    test_wrap();
    test_hold();
    test_sweep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule